// File: doc/BRIEF.md
# Write-only peripheral bus requester bridge

This block turns simple write commands from a local requester into two-phase APB write transfers across a set of peripheral slots. The command carries a slot index, an address, write data, byte strobes and protection bits. The bridge raises the select line of the addressed slot for one Setup cycle, then raises the enable line and holds every bus output frozen until that slot signals ready. It then reports completion, together with the error status of the slot, back to the request side.

Consecutive writes to the same slot run back to back: the select line stays high and a fresh Setup cycle follows the completing cycle straight away. A write to a different slot costs one idle cycle with no select asserted. Slots flagged at elaboration as legacy have no ready or error wires of their own. Their ready input is treated as always high and their error input as always low, so every write to them takes exactly two cycles.

Top module: `apb_wr_bridge`

## Requirements
- R1: A synchronous active-high reset places the block in idle, with every `psel` bit, `penable`, `done_valid` and `done_err` low and `req_ready` high.
- R2: In the cycle after a command is accepted (`req_valid` and `req_ready` both high at a rising edge) from idle, the block is in Setup. Only `psel` bit i is high, where i equals `req_slot`, `penable` is low, `pwrite` is high, and `paddr`, `pwdata`, `pstrb` and `pprot` equal the command fields.
- R3: Setup lasts exactly one cycle. `penable` rises on the next edge whatever the `pready` and `pslverr` inputs are.
- R4: While `penable` is high and the selected slot's effective ready is low, `psel`, `penable`, `pwrite`, `paddr`, `pwdata`, `pstrb` and `pprot` all keep their values.
- R5: A transfer completes at the edge where `penable` is high and the selected slot's effective ready is high. `done_valid` is high in exactly the cycle after each completion.
- R6: `done_err` is high with `done_valid` only if the selected slot's `pslverr` was high in the completing cycle. `pslverr` in any other cycle has no effect.
- R7: `req_ready` is high exactly when the block is idle or is in a completing Access cycle.
- R8: If a command for the same slot is accepted in the completing cycle, the next cycle is a Setup with the same `psel` bit still high, `penable` low and the new command fields.
- R9: If a command for a different slot is accepted in the completing cycle, the next cycle has all `psel` bits low, and the cycle after that is the Setup of the new command.
- R10: If no command is accepted in the completing cycle, `psel` and `penable` are all low in the next cycle and the block is idle.
- R11: For a slot whose bit is set in `LEGACY_SLOTS`, that slot's `pready` is treated as 1 and its `pslverr` as 0. Each write to it completes in its first Access cycle with `done_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command taken at this edge when valid |
| req_slot | input | SLOT_W | Target slot index |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte strobes |
| req_prot | input | 3 | Protection bits |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error status of the completed write |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction, high while selected |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobes |
| pprot | output | 3 | Bus protection bits |
| psel | output | NUM_SLOTS | One select line per slot |
| penable | output | 1 | Access phase marker |
| pready | input | NUM_SLOTS | Ready from each slot |
| pslverr | input | NUM_SLOTS | Error from each slot |

## Verification
Each result falls due at a fixed cycle. `req_ready` is combinational in the same cycle as the inputs. The Setup outputs appear one edge after acceptance, and `penable` rises one edge after that. `done_valid` and `done_err` appear one edge after the completing edge. The gap cycle and then the new Setup follow a slot change on successive edges. The bench drives inputs on the falling edge, checks `req_ready` a moment later in the same cycle, and predicts every registered output one edge ahead. At the next falling edge it compares those outputs, so each check samples in the cycle where that result is due.

// File: rtl/apb_wr_pkg.sv
package apb_wr_pkg;
  localparam int PROT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_GAP    = 2'd3
  } wr_state_t;
endpackage

// File: rtl/apb_wr_slot_resp.sv
module apb_wr_slot_resp #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W = 2,
  parameter logic [NUM_SLOTS-1:0] LEGACY_SLOTS = '0
) (
  input  logic [NUM_SLOTS-1:0] pready,
  input  logic [NUM_SLOTS-1:0] pslverr,
  input  logic [SLOT_W-1:0]    sel_idx,
  output logic                 eff_ready,
  output logic                 eff_err
);
  logic [NUM_SLOTS-1:0] rdy_v;
  logic [NUM_SLOTS-1:0] err_v;

  // Legacy slots: ready forced high, error forced low (R11)
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (LEGACY_SLOTS[i]) begin : g_legacy
      assign rdy_v[i] = 1'b1;
      assign err_v[i] = 1'b0;
    end else begin : g_live
      assign rdy_v[i] = pready[i];
      assign err_v[i] = pslverr[i];
    end
  end

  assign eff_ready = rdy_v[sel_idx];
  assign eff_err   = err_v[sel_idx];
endmodule

// File: rtl/apb_wr_fsm.sv
module apb_wr_fsm
  import apb_wr_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              eff_ready,
  output logic              req_ready,
  output logic              accept,
  output logic              complete,
  output wr_state_t         state_d
);
  wr_state_t state_q;
  logic      same_slot;

  always_comb begin
    complete  = (state_q == ST_ACCESS) && eff_ready;
    req_ready = (state_q == ST_IDLE) || complete;
    accept    = req_valid && req_ready;
    same_slot = (req_slot == cur_slot);
    state_d   = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (complete) begin
          if (!accept)        state_d = ST_IDLE;
          else if (same_slot) state_d = ST_SETUP;
          else                state_d = ST_GAP;
        end
      end
      ST_GAP:    state_d = ST_SETUP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R3: Setup never lasts more than one cycle
  assert_setup_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SETUP |=> state_q == ST_ACCESS);

  // R9: the idle gap between slots is a single cycle
  assert_gap_single_R9: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_GAP |=> state_q == ST_SETUP);

  // R7: nothing is taken while a transfer is mid-flight
  assert_no_take_in_setup_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETUP || state_q == ST_GAP) |-> !req_ready);
endmodule

// File: rtl/apb_wr_datapath.sv
module apb_wr_datapath
  import apb_wr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 complete,
  input  logic                 eff_err,
  input  wr_state_t            state_d,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [STRB_W-1:0]    req_strb,
  input  logic [PROT_W-1:0]    req_prot,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic [ADDR_W-1:0]    paddr,
  output logic                 pwrite,
  output logic [DATA_W-1:0]    pwdata,
  output logic [STRB_W-1:0]    pstrb,
  output logic [PROT_W-1:0]    pprot,
  output logic [NUM_SLOTS-1:0] psel,
  output logic                 penable,
  output logic                 done_valid,
  output logic                 done_err
);
  logic [SLOT_W-1:0]    slot_d;
  logic                 active_d;
  logic [NUM_SLOTS-1:0] psel_d;

  assign slot_d   = accept ? req_slot : cur_slot;
  assign active_d = (state_d == ST_SETUP) || (state_d == ST_ACCESS);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign psel_d[i] = active_d && (slot_d == SLOT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_slot   <= '0;
      paddr      <= '0;
      pwdata     <= '0;
      pstrb      <= '0;
      pprot      <= '0;
      pwrite     <= 1'b0;
      psel       <= '0;
      penable    <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      cur_slot <= slot_d;
      if (accept) begin
        paddr  <= req_addr;
        pwdata <= req_data;
        pstrb  <= req_strb;
        pprot  <= req_prot;
      end
      pwrite     <= active_d;
      psel       <= psel_d;
      penable    <= (state_d == ST_ACCESS);
      done_valid <= complete;
      done_err   <= complete && eff_err;
    end
  end

  // R2: at most one slot selected
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(psel));

  // R3: enable only ever accompanies a select
  assert_enable_with_sel_R3: assert property (@(posedge clk) disable iff (rst)
    penable |-> (psel != '0) && pwrite);
endmodule

// File: rtl/apb_wr_bridge.sv
module apb_wr_bridge
  import apb_wr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [NUM_SLOTS-1:0] LEGACY_SLOTS = '0,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [STRB_W-1:0]    req_strb,
  input  logic [PROT_W-1:0]    req_prot,
  output logic                 done_valid,
  output logic                 done_err,
  output logic [ADDR_W-1:0]    paddr,
  output logic                 pwrite,
  output logic [DATA_W-1:0]    pwdata,
  output logic [STRB_W-1:0]    pstrb,
  output logic [PROT_W-1:0]    pprot,
  output logic [NUM_SLOTS-1:0] psel,
  output logic                 penable,
  input  logic [NUM_SLOTS-1:0] pready,
  input  logic [NUM_SLOTS-1:0] pslverr
);
  logic              eff_ready;
  logic              eff_err;
  logic              accept;
  logic              complete;
  logic [SLOT_W-1:0] cur_slot;
  wr_state_t         state_d;

  apb_wr_slot_resp #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .LEGACY_SLOTS(LEGACY_SLOTS)
  ) u_resp (
    .pready(pready), .pslverr(pslverr), .sel_idx(cur_slot),
    .eff_ready(eff_ready), .eff_err(eff_err)
  );

  apb_wr_fsm #(.SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_slot(req_slot),
    .cur_slot(cur_slot), .eff_ready(eff_ready), .req_ready(req_ready),
    .accept(accept), .complete(complete), .state_d(state_d)
  );

  apb_wr_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STRB_W(STRB_W)
  ) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .complete(complete),
    .eff_err(eff_err), .state_d(state_d), .req_slot(req_slot),
    .req_addr(req_addr), .req_data(req_data), .req_strb(req_strb),
    .req_prot(req_prot), .cur_slot(cur_slot), .paddr(paddr),
    .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
    .psel(psel), .penable(penable), .done_valid(done_valid),
    .done_err(done_err)
  );

  // R4: bus frozen through wait cycles
  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    penable && !eff_ready |=> penable && $stable(psel) && $stable(paddr)
      && $stable(pwdata) && $stable(pstrb) && $stable(pprot) && pwrite);

  // R5: every completion is reported on the following cycle
  assert_done_after_complete_R5: assert property (@(posedge clk) disable iff (rst)
    penable && eff_ready |=> done_valid);

  // R5: no report without a completing access
  assert_done_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
    !penable |=> !done_valid);

  // R11: legacy slots leave Access after one cycle
  assert_legacy_two_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    penable && LEGACY_SLOTS[cur_slot] |=> !penable);
endmodule

// File: tb/apb_wr_bridge_test.sv
module apb_wr_bridge_test;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam int BW = DW / 8;
  localparam logic [NS-1:0] LEG = 4'b1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SW-1:0] req_slot = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [BW-1:0] req_strb = '0;
  logic [2:0]    req_prot = '0;
  logic done_valid, done_err, pwrite, penable;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [BW-1:0] pstrb;
  logic [2:0]    pprot;
  logic [NS-1:0] psel;
  logic [NS-1:0] pready = '0;
  logic [NS-1:0] pslverr = '0;

  apb_wr_bridge #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .LEGACY_SLOTS(LEG)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_slot(req_slot), .req_addr(req_addr), .req_data(req_data),
    .req_strb(req_strb), .req_prot(req_prot), .done_valid(done_valid),
    .done_err(done_err), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
    .pstrb(pstrb), .pprot(pprot), .psel(psel), .penable(penable),
    .pready(pready), .pslverr(pslverr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // expectations for the next cycle
  logic [NS-1:0] e_psel = '0;
  logic e_pen = 1'b0, e_done = 1'b0, e_err = 1'b0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;
  logic [BW-1:0] e_strb = '0;
  logic [2:0]    e_prot = '0;
  string t_bus = "R1", t_err = "R1";
  logic in_gap = 1'b0;
  logic [SW-1:0] g_slot = '0;
  logic [AW-1:0] g_addr = '0;
  logic [DW-1:0] g_data = '0;
  logic [BW-1:0] g_strb = '0;
  logic [2:0]    g_prot = '0;
  logic took = 1'b0;
  int wait_cnt = 0;
  int n_same = 0, n_diff = 0, n_leg_low = 0, n_err = 0, n_long = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [NS-1:0] onehot(input logic [SW-1:0] s);
    return NS'(1) << s;
  endfunction

  function automatic logic [SW-1:0] slot_of(input logic [NS-1:0] v);
    logic [SW-1:0] r = '0;
    for (int i = 0; i < NS; i++) if (v[i]) r = SW'(i);
    return r;
  endfunction

  task automatic load_exp(input logic [SW-1:0] s, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [BW-1:0] b,
                          input logic [2:0] p);
    e_psel = onehot(s); e_pen = 1'b0;
    e_addr = a; e_data = d; e_strb = b; e_prot = p;
  endtask

  task automatic run_cycle(input int ready_pct, input int req_pct, input int wait_lim);
    logic idle_now, act, cmp, err_now;
    logic [SW-1:0] cur;
    @(negedge clk);
    cyc++;
    // compare registered outputs against last cycle's prediction
    check(psel == e_psel, {t_bus, " psel"}, 64'(psel), 64'(e_psel));
    check(penable == e_pen, {t_bus, " penable"}, 64'(penable), 64'(e_pen));
    if (e_psel != '0) begin
      check(paddr == e_addr, {t_bus, " paddr"}, 64'(paddr), 64'(e_addr));
      check(pwdata == e_data, {t_bus, " pwdata"}, 64'(pwdata), 64'(e_data));
      check(pstrb == e_strb && pprot == e_prot, {t_bus, " pstrb/pprot"},
            64'({pstrb, pprot}), 64'({e_strb, e_prot}));
      check(pwrite == 1'b1, "R2 pwrite", 64'(pwrite), 64'd1);
    end
    check(done_valid == e_done, "R5 done_valid", 64'(done_valid), 64'(e_done));
    check(done_err == e_err, {t_err, " done_err"}, 64'(done_err), 64'(e_err));

    // drive new inputs
    if (took) req_valid = 1'b0;
    if (!req_valid && ($urandom % 100) < req_pct) begin
      req_valid = 1'b1;
      req_slot  = (($urandom % 2) == 0) ? slot_of(psel) : SW'($urandom % NS);
      req_addr  = AW'($urandom);
      req_data  = $urandom;
      req_strb  = BW'($urandom);
      req_prot  = 3'($urandom);
    end
    for (int s = 0; s < NS; s++) begin
      pready[s]  = (wait_cnt >= wait_lim) || (($urandom % 100) < ready_pct);
      pslverr[s] = ($urandom % 3) == 0;
    end
    #1;
    act = (psel != '0);
    cur = slot_of(psel);
    cmp = penable && act && (LEG[cur] || pready[cur]);
    err_now = !LEG[cur] && pslverr[cur];
    idle_now = !act && !penable && !in_gap;
    check(req_ready == (idle_now || cmp), "R7 req_ready", 64'(req_ready),
          64'(idle_now || cmp));
    took = req_valid && req_ready;

    e_done = cmp;
    e_err  = cmp && err_now;
    t_err  = (cmp && LEG[cur]) ? "R11" : "R6";
    if (cmp && err_now) n_err++;
    if (cmp && LEG[cur] && !pready[cur]) n_leg_low++;

    if (in_gap) begin
      load_exp(g_slot, g_addr, g_data, g_strb, g_prot);
      in_gap = 1'b0; t_bus = "R9 new setup";
    end else if (!act && !penable) begin
      if (took) begin
        load_exp(req_slot, req_addr, req_data, req_strb, req_prot);
        t_bus = "R2";
      end else begin
        e_psel = '0; e_pen = 1'b0; t_bus = "R10";
      end
    end else if (act && !penable) begin
      e_pen = 1'b1; t_bus = "R3";
    end else if (!cmp) begin
      wait_cnt++;
      t_bus = "R4";
    end else begin
      if (wait_cnt >= 8) n_long++;
      wait_cnt = 0;
      if (!took) begin
        e_psel = '0; e_pen = 1'b0; t_bus = "R10";
      end else if (req_slot == cur) begin
        load_exp(req_slot, req_addr, req_data, req_strb, req_prot);
        t_bus = "R8"; n_same++;
      end else begin
        e_psel = '0; e_pen = 1'b0; t_bus = "R9 gap";
        in_gap = 1'b1; n_diff++;
        g_slot = req_slot; g_addr = req_addr; g_data = req_data;
        g_strb = req_strb; g_prot = req_prot;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(psel == '0 && !penable, "R1 bus idle in reset", 64'({psel, penable}), 64'd0);
    check(!done_valid && !done_err, "R1 done low in reset", 64'({done_valid, done_err}), 64'd0);
    rst = 1'b0;
    #1;
    check(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    // directed: legacy slot while its pready is low (R11)
    req_valid = 1'b1; req_slot = 2'd3; req_addr = 16'h0BEE;
    req_data = 32'hCAFE_0003; req_strb = 4'hF; req_prot = 3'd2;
    pready = '0;
    #1;
    took = req_valid && req_ready;
    load_exp(req_slot, req_addr, req_data, req_strb, req_prot);
    t_bus = "R2";
    e_done = 1'b0; e_err = 1'b0;
    for (int k = 0; k < 400; k++) run_cycle(0, 0, 1000);
    for (int k = 0; k < 1500; k++) run_cycle(90, 85, 3);
    for (int k = 0; k < 1500; k++) run_cycle(40, 60, 6);
    for (int k = 0; k < 1500; k++) run_cycle(0, 70, 12);
    req_valid = 1'b0;
    for (int k = 0; k < 40; k++) run_cycle(100, 0, 0);
    check(n_same > 0, "R8 back-to-back same slot seen", 64'(n_same), 64'd1);
    check(n_diff > 0, "R9 slot change seen", 64'(n_diff), 64'd1);
    check(n_leg_low > 0, "R11 legacy completion with pready low seen", 64'(n_leg_low), 64'd1);
    check(n_err > 0, "R6 error completion seen", 64'(n_err), 64'd1);
    check(n_long > 0, "R4 long wait seen", 64'(n_long), 64'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule